// File: doc/BRIEF.md
# Vectored Interrupt Status Controller

This block sits beside a small microcontroller core and turns a handful of interrupt sources into one vectored request. It keeps three stored source flags (external INT pin edge, timer overflow, counter-clock pin edge), four enable bits, and a live summary of a peripheral flag bank. Pulses from the edge detectors and the timer, which sit outside this block, set the flags. The peripheral summary is recomputed every cycle from the peripheral flags and their per-peripheral enables. All eight bits are visible as one status/control byte through a simple register port.

When the global disable input is low and some flag meets its enable, the block offers a vector address to the core over a valid/ready channel. The offer is registered and held unchanged until the core accepts it with a single-cycle `vec_ready` pulse. There is no back-pressure in the other direction: the block never waits on the core except to hold its offer, and it ignores `vec_ready` while `vec_valid` is low. Accepting a source vector clears that source's stored flag. The peripheral summary is never cleared here. It falls only when the peripheral bank changes.

A hazard case is handled on purpose. If software clears an enable in the same cycle that its flag rises, and the global disable is low, the block latches a pending reset-vector request and offers vector 00h ahead of everything else.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status byte reads 00h and `vec_valid` is low.
- R2: The status byte is at register address 07h. Bit 7 is the peripheral summary, bit 6 the counter-clock pin flag, bit 5 the timer flag, bit 4 the INT pin flag, bit 3 the peripheral enable, bit 2 the counter-clock pin enable, bit 1 the timer enable and bit 0 the INT enable. A write at 07h loads bits 6..0. Other addresses read 00h, and writes to them change nothing.
- R3: Bit 7 reads as the OR over all peripherals of flag AND enable, follows those inputs in the same cycle, and is not changed by writes.
- R4: Each source event pulse sets its flag on the next clock edge, whatever the enables and the global disable are doing. An event beats a software write of 0 to the same flag in the same cycle.
- R5: While `glb_dis` is high no new offer starts. Otherwise an offer starts one cycle after a flag and its enable are both set in the register, so it comes two clock edges after a source event.
- R6: Pending enabled sources are served in the order INT pin (08h), timer (10h), counter-clock pin (18h), peripheral (20h).
- R7: Once `vec_valid` is high it stays high with `vec_addr` unchanged until a cycle with `vec_ready` high. That cycle is the acceptance, and `vec_valid` is low in the next cycle.
- R8: Accepting a source vector clears that source's flag. If a new event for the same source arrives in the acceptance cycle, the flag stays set and is offered again. Accepting 20h leaves the peripheral bits alone.
- R9: A write that takes an enable from 1 to 0 in the same cycle as its flag rises, with `glb_dis` low, leads to an offer of 00h before any other vector. With `glb_dis` high no such offer is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register port address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| evt_int | input | 1 | INT pin edge event pulse |
| evt_tmr | input | 1 | Timer overflow event pulse |
| evt_tck | input | 1 | Counter-clock pin edge event pulse |
| per_flags | input | NPER | Peripheral flag bank |
| per_enables | input | NPER | Per-peripheral enable bank |
| glb_dis | input | 1 | Global interrupt disable |
| vec_valid | output | 1 | Vector offer valid |
| vec_ready | input | 1 | Core accepts the vector (one-cycle pulse) |
| vec_addr | output | 8 | Offered vector address |

## Verification
Timing is counted in clock edges. A flag is visible on the register port one edge after its event pulse, and an offer appears one edge after that. A flag cleared by acceptance is gone on the edge that drops `vec_valid`. The peripheral summary is combinational and is checked in the same cycle its inputs change. The bench drives inputs just after a falling edge and samples just before driving at the next falling edge. Each check is therefore placed at a counted number of rising edges after its stimulus, and one-cycle-early and one-cycle-late results are checked as wrong where the requirement fixes the timing.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC       = 4;            // INT, timer, counter-clock, peripheral
  localparam int NHW        = 3;            // sources with a stored flag
  localparam int REG_W      = 2 * NSRC;     // flags over enables
  localparam int VEC_W      = 8;
  localparam int VEC_STRIDE = 8;

  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_TMR = 2'd1,
    SRC_TCK = 2'd2,
    SRC_PER = 2'd3
  } src_e;

  localparam logic [VEC_W-1:0] VEC_RESET = '0;

  // Source i vectors to (i+1)*stride; lower index wins.
  function automatic logic [VEC_W-1:0] vec_of(input int idx);
    return VEC_W'((idx + 1) * VEC_STRIDE);
  endfunction
endpackage

// File: rtl/irqc_per_summary.sv
module irqc_per_summary #(
  parameter int NPER = 8
) (
  input  logic [NPER-1:0] flags,
  input  logic [NPER-1:0] enables,
  output logic            any_pending
);
  logic [NPER-1:0] hit;

  generate
    for (genvar gi = 0; gi < NPER; gi++) begin : g_hit
      assign hit[gi] = flags[gi] & enables[gi];
    end
  endgenerate

  assign any_pending = |hit;
endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NHW-1:0]   evt,
  input  logic [NHW-1:0]   clr,
  input  logic             wr,
  input  logic [REG_W-2:0] wdata,
  output logic [NHW-1:0]   flags,
  output logic [NSRC-1:0]  en,
  output logic [NSRC-1:0]  en_drop
);
  // Flag update order: source event, then acceptance clear, then software write.
  generate
    for (genvar gi = 0; gi < NHW; gi++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n)          flags[gi] <= 1'b0;
        else if (evt[gi])    flags[gi] <= 1'b1;
        else if (clr[gi])    flags[gi] <= 1'b0;
        else if (wr)         flags[gi] <= wdata[NSRC+gi];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)  en <= '0;
    else if (wr) en <= wdata[NSRC-1:0];
  end

  // Enables that this cycle's write takes from 1 to 0.
  assign en_drop = wr ? (en & ~wdata[NSRC-1:0]) : '0;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_dis,
  input  logic [NSRC-1:0]  pend,
  input  logic             rst_req,
  input  logic             vec_ready,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_addr,
  output logic [NHW-1:0]   clr_hw
);
  logic             rst_pend;
  logic [NSRC-1:0]  sel_q;      // all zero means the reset vector
  logic [NSRC-1:0]  pick;
  logic [VEC_W-1:0] pick_addr;
  logic             found;
  logic             offer;
  logic             accept;

  always_comb begin
    pick      = '0;
    pick_addr = VEC_RESET;
    found     = rst_pend;
    for (int i = 0; i < NSRC; i++) begin
      if (!found && pend[i]) begin
        pick[i]   = 1'b1;
        pick_addr = vec_of(i);
        found     = 1'b1;
      end
    end
  end

  assign offer  = !vec_valid && !glb_dis && (rst_pend || (|pend));
  assign accept = vec_valid && vec_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_addr  <= '0;
      sel_q     <= '0;
    end else if (offer) begin
      vec_valid <= 1'b1;
      vec_addr  <= pick_addr;
      sel_q     <= pick;
    end else if (accept) begin
      vec_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      rst_pend <= 1'b0;
    else if (rst_req)                rst_pend <= 1'b1;
    else if (accept && sel_q == '0)  rst_pend <= 1'b0;
  end

  assign clr_hw = accept ? sel_q[NHW-1:0] : '0;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irqc_pkg::*;
#(
  parameter int              NPER     = 8,
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              evt_int,
  input  logic              evt_tmr,
  input  logic              evt_tck,
  input  logic [NPER-1:0]   per_flags,
  input  logic [NPER-1:0]   per_enables,
  input  logic              glb_dis,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [VEC_W-1:0]  vec_addr
);
  logic [NHW-1:0]  evt;
  logic [NHW-1:0]  hw_flags;
  logic [NHW-1:0]  clr_hw;
  logic [NSRC-1:0] en;
  logic [NSRC-1:0] en_drop;
  logic [NSRC-1:0] all_flags;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] rise;
  logic            per_sum;
  logic            per_sum_q;
  logic            wr_hit;
  logic            rst_req;

  assign evt    = {evt_tck, evt_tmr, evt_int};
  assign wr_hit = reg_wr && (reg_addr == REG_ADDR);

  irqc_per_summary #(.NPER(NPER)) u_per_sum (
    .flags       (per_flags),
    .enables     (per_enables),
    .any_pending (per_sum)
  );

  irqc_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .clr     (clr_hw),
    .wr      (wr_hit),
    .wdata   (reg_wdata[REG_W-2:0]),
    .flags   (hw_flags),
    .en      (en),
    .en_drop (en_drop)
  );

  // Previous summary, to spot the cycle the peripheral flag rises.
  always_ff @(posedge clk) begin
    if (!rst_n) per_sum_q <= 1'b0;
    else        per_sum_q <= per_sum;
  end

  assign all_flags = {per_sum, hw_flags};
  assign pend      = all_flags & en;
  assign rise      = {per_sum & ~per_sum_q, evt};
  assign rst_req   = !glb_dis && (|(en_drop & rise));

  irqc_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_dis   (glb_dis),
    .pend      (pend),
    .rst_req   (rst_req),
    .vec_ready (vec_ready),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr),
    .clr_hw    (clr_hw)
  );

  assign reg_rdata = (reg_addr == REG_ADDR) ? {all_flags, en} : '0;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int                NPER     = 8,
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h07
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glb_dis,
  input logic              vec_valid,
  input logic              vec_ready,
  input logic [VEC_W-1:0]  vec_addr,
  input logic [NHW-1:0]    evt,
  input logic [NHW-1:0]    hw_flags,
  input logic [NSRC-1:0]   en,
  input logic [NPER-1:0]   per_flags,
  input logic [NPER-1:0]   per_enables,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata
);
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_addr))); // R7

  AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> !vec_valid); // R7

  AST_NO_OFFER_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_valid && glb_dis) |=> !vec_valid); // R5

  AST_LEGAL_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr[2:0] == 3'd0 && vec_addr <= vec_of(NSRC-1))); // R6

  AST_PEIF_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == REG_ADDR) |-> (reg_rdata[REG_W-1] == (|(per_flags & per_enables)))); // R3

  AST_RO_BIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == REG_ADDR && reg_wdata[REG_W-1] && !(|(per_flags & per_enables)))
      |-> !reg_rdata[REG_W-1]); // R3

  AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == REG_ADDR) |=> (en == $past(reg_wdata[NSRC-1:0]))); // R2

  generate
    for (genvar gi = 0; gi < NHW; gi++) begin : g_src
      AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        evt[gi] |=> hw_flags[gi]); // R4

      AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_ready && vec_addr == vec_of(gi) && !evt[gi]) |=> !hw_flags[gi]); // R8
    end
  endgenerate
endmodule

bind irq_status_ctrl irqc_checker #(
  .NPER     (NPER),
  .ADDR_W   (ADDR_W),
  .REG_ADDR (REG_ADDR)
) u_irqc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .glb_dis     (glb_dis),
  .vec_valid   (vec_valid),
  .vec_ready   (vec_ready),
  .vec_addr    (vec_addr),
  .evt         (evt),
  .hw_flags    (hw_flags),
  .en          (en),
  .per_flags   (per_flags),
  .per_enables (per_enables),
  .reg_addr    (reg_addr),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata)
);

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NPER = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = 8'h07;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       evt_int = 1'b0, evt_tmr = 1'b0, evt_tck = 1'b0;
  logic [NPER-1:0] per_flags = '0, per_enables = '0;
  logic       glb_dis = 1'b0;
  logic       vec_valid;
  logic       vec_ready = 1'b0;
  logic [7:0] vec_addr;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl #(.NPER(NPER)) i_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_int(evt_int),
    .evt_tmr(evt_tmr), .evt_tck(evt_tck), .per_flags(per_flags),
    .per_enables(per_enables), .glb_dis(glb_dis), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_addr(vec_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    nxt();
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    nxt();
    reg_wr = 1'b0; reg_addr = 8'h07;
    #1;
  endtask

  task automatic ack();
    nxt();
    vec_ready = 1'b1;
    nxt();
    vec_ready = 1'b0;
    #1;
  endtask

  task automatic wait_valid(output logic [7:0] a);
    a = 8'hxx;
    for (int i = 0; i < 8; i++) begin
      if (vec_valid) begin
        a = vec_addr;
        break;
      end
      nxt();
      #1;
    end
  endtask

  task automatic quiet(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      nxt(); #1;
      check(req, 32'(vec_valid), 32'd0);
    end
  endtask

  task automatic t_reset();
    #1;
    check("R1 status byte", 32'(reg_rdata), 32'h00);
    check("R1 valid low", 32'(vec_valid), 32'd0);
  endtask

  task automatic t_regrw();
    glb_dis = 1'b1;
    write_reg(8'h07, 8'hFF);
    check("R2 write loads bits 6..0", 32'(reg_rdata), 32'h7F);
    write_reg(8'h06, 8'h00);
    check("R2 other address write ignored", 32'(reg_rdata), 32'h7F);
    reg_addr = 8'h06; #1;
    check("R2 other address reads zero", 32'(reg_rdata), 32'h00);
    reg_addr = 8'h07;
    write_reg(8'h07, 8'h5A);
    check("R2 bit layout", 32'(reg_rdata), 32'h5A);
    write_reg(8'h07, 8'h00);
    check("R2 cleared", 32'(reg_rdata), 32'h00);
  endtask

  task automatic t_peif();
    glb_dis = 1'b1;
    nxt();
    per_flags = 8'b0000_0101; per_enables = 8'b0000_0010; #1;
    check("R3 no flag meets enable", 32'(reg_rdata[7]), 32'd0);
    per_enables = 8'b0000_0100; #1;
    check("R3 live summary", 32'(reg_rdata[7]), 32'd1);
    per_flags = 8'h00;
    write_reg(8'h07, 8'h80);
    check("R3 write of bit 7 ignored", 32'(reg_rdata), 32'h00);
    per_enables = 8'h00;
  endtask

  task automatic t_masked();
    glb_dis = 1'b1;
    nxt(); evt_tmr = 1'b1;
    nxt(); evt_tmr = 1'b0; #1;
    check("R4 flag set with enables clear and disable high", 32'(reg_rdata), 32'h20);
    nxt();
    reg_wr = 1'b1; reg_wdata = 8'h00; evt_int = 1'b1;
    nxt();
    reg_wr = 1'b0; evt_int = 1'b0; #1;
    check("R4 event beats write of 0", 32'(reg_rdata), 32'h10);
    glb_dis = 1'b0;
    quiet("R5 no offer without enable", 3);
    write_reg(8'h07, 8'h00);
  endtask

  task automatic t_single();
    logic [7:0] a;
    glb_dis = 1'b0;
    write_reg(8'h07, 8'h01);
    nxt(); evt_int = 1'b1;
    nxt(); evt_int = 1'b0; #1;
    check("R5 not offered one edge after event", 32'(vec_valid), 32'd0);
    check("R4 flag visible one edge after event", 32'(reg_rdata), 32'h11);
    nxt(); #1;
    check("R5 offered two edges after event", 32'(vec_valid), 32'd1);
    check("R6 INT vector", 32'(vec_addr), 32'h08);
    for (int i = 0; i < 3; i++) begin
      nxt(); #1;
      check("R7 held without ready", 32'({vec_valid, vec_addr}), 32'h108);
    end
    ack();
    check("R7 valid drops after acceptance", 32'(vec_valid), 32'd0);
    check("R8 flag cleared by acceptance", 32'(reg_rdata), 32'h01);
    quiet("R8 no repeat offer", 2);
    write_reg(8'h07, 8'h00);
    a = 8'h00;
  endtask

  task automatic t_priority();
    logic [7:0] a;
    logic [7:0] order [4] = '{8'h08, 8'h10, 8'h18, 8'h20};
    glb_dis = 1'b1;
    write_reg(8'h07, 8'h0F);
    nxt();
    evt_int = 1'b1; evt_tmr = 1'b1; evt_tck = 1'b1;
    per_flags = 8'h01; per_enables = 8'h01;
    nxt();
    evt_int = 1'b0; evt_tmr = 1'b0; evt_tck = 1'b0; #1;
    check("R4 all flags set", 32'(reg_rdata), 32'hFF);
    quiet("R5 disable blocks offers", 2);
    glb_dis = 1'b0;
    for (int k = 0; k < 4; k++) begin
      wait_valid(a);
      check("R6 priority order", 32'(a), 32'(order[k]));
      if (k == 3) begin
        nxt(); vec_ready = 1'b1;
        #1;
        check("R8 peripheral bit kept at acceptance", 32'(reg_rdata[7]), 32'd1);
        per_flags = 8'h00;
        nxt(); vec_ready = 1'b0; #1;
      end else begin
        ack();
      end
    end
    check("R8 source flags cleared, enables kept", 32'(reg_rdata), 32'h0F);
    quiet("R6 nothing left", 3);
    per_enables = 8'h00;
    write_reg(8'h07, 8'h00);
  endtask

  task automatic t_race();
    logic [7:0] a;
    glb_dis = 1'b0;
    write_reg(8'h07, 8'h04);
    nxt(); evt_tck = 1'b1;
    nxt(); evt_tck = 1'b0;
    wait_valid(a);
    check("R6 counter-clock vector", 32'(a), 32'h18);
    nxt(); vec_ready = 1'b1; evt_tck = 1'b1;
    nxt(); vec_ready = 1'b0; evt_tck = 1'b0; #1;
    check("R8 new event at acceptance keeps flag", 32'(reg_rdata), 32'h44);
    wait_valid(a);
    check("R8 offered again", 32'(a), 32'h18);
    ack();
    check("R8 cleared after second acceptance", 32'(reg_rdata), 32'h04);
    write_reg(8'h07, 8'h00);
  endtask

  task automatic t_reset_vec();
    logic [7:0] a;
    glb_dis = 1'b0;
    write_reg(8'h07, 8'h03);
    nxt();
    reg_wr = 1'b1; reg_wdata = 8'h01; evt_tmr = 1'b1; evt_int = 1'b1;
    nxt();
    reg_wr = 1'b0; evt_tmr = 1'b0; evt_int = 1'b0; #1;
    check("R9 not offered one edge after", 32'(vec_valid), 32'd0);
    nxt(); #1;
    check("R9 offered two edges after", 32'(vec_valid), 32'd1);
    check("R9 reset vector first", 32'(vec_addr), 32'h00);
    ack();
    check("R9 flags untouched by reset vector", 32'(reg_rdata), 32'h31);
    wait_valid(a);
    check("R9 then INT vector", 32'(a), 32'h08);
    ack();
    check("R9 timer flag left, enable off", 32'(reg_rdata), 32'h21);
    quiet("R9 single reset offer", 3);
    write_reg(8'h07, 8'h02);
    glb_dis = 1'b1;
    nxt();
    reg_wr = 1'b1; reg_wdata = 8'h00; evt_tmr = 1'b1;
    nxt();
    reg_wr = 1'b0; evt_tmr = 1'b0;
    quiet("R9 none under disable", 2);
    glb_dis = 1'b0;
    quiet("R9 none after disable lifts", 3);
    check("R9 flag only", 32'(reg_rdata), 32'h20);
    write_reg(8'h07, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) nxt();
    rst_n = 1'b1;
    t_reset();
    t_regrw();
    t_peif();
    t_masked();
    t_single();
    t_priority();
    t_race();
    t_reset_vec();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule